// File: doc/BRIEF.md
# Frame-Rate Window Checker with Crystal Fallback

This block watches a recovered bi-phase audio stream and decides if its frame rate can be trusted. It counts crystal-clock cycles between consecutive frame strobes from the receiver. It then compares that period against a window set by the PLL multiplier mode, optionally narrowed by a 2-bit limit field. When the stream is out of range, or stops arriving, the block raises an error and moves the system clock selection from the PLL clock to the crystal clock.

A short filter keeps one stray measurement from toggling the clock source. Two consecutive bad measurements assert the fault. Two consecutive good measurements clear it. The most recent measured period is presented on a port, so the rate can be read without further logic.

Top module: `rc_rate_checker`

## Requirements
- R1: Reset (active-low `rst_n`) drives `rate_err` = 1, `sel_xtal` = 1 (crystal clock selected) and `period_cnt` = 0.
- R2: `period_cnt` takes the number of `clk_xtal` edges between two consecutive sampled strobes, one edge after the later strobe. The first strobe after reset, and the first strobe after a timeout, only start a measurement and leave `period_cnt` unchanged.
- R3: With `mode_256` = 0 and `lim_sel` = 0, a period is good if it lies between 28 kHz and 105 kHz of the crystal rate. At the default 12.288 MHz that is 118..438 cycles inclusive; 117 and 439 are bad.
- R4: With `mode_256` = 1 and `lim_sel` = 0, the upper rate is 195 kHz, so the good range is 64..438 cycles at defaults; 63 is bad.
- R5: `lim_sel` values 1, 2 and 3 cap the upper rate at 48, 96 and 192 kHz, clipped to the mode's own maximum. At defaults the minimum periods are 256, 128, and 118 (mode 0) or 64 (mode 1).
- R6: Two consecutive bad measurements set `rate_err` and `sel_xtal` on the edge of the second one.
- R7: A single bad measurement between good ones changes neither `rate_err` nor `sel_xtal`. Neither output changes on a cycle without a measurement or timeout.
- R8: Two consecutive good measurements clear `rate_err` and return `sel_xtal` to 0 (PLL clock). One good measurement alone does not.
- R9: If no strobe arrives for 1.5 times the longest good period (657 cycles at defaults), that counts as one bad measurement. It repeats every further 657 quiet cycles, and `period_cnt` never exceeds it.
- R10: `sel_xtal` equals `rate_err` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| mode_256 | input | 1 | 0 = 512x PLL mode, 1 = 256x PLL mode |
| lim_sel | input | 2 | Extra upper-rate limit, 0 = none |
| rate_err | output | 1 | Registered rate fault flag |
| sel_xtal | output | 1 | 1 = crystal clock source selected |
| period_cnt | output | CW (10 at defaults) | Last measured frame period in crystal cycles |

## Verification
The bound checker watches, on every cycle, the invariants that need no knowledge of the stream: the reset state, `sel_xtal` matching `rate_err`, the outputs holding on cycles with no measurement, the period register changing only after a strobe, and the period ceiling. The exact window edges for each mode and limit setting, the two-in-a-row hysteresis in both directions, and the timeout counting only show up in the bench's directed scenarios, which place strobes one cycle inside and outside each bound.

// File: rtl/rc_pkg.sv
package rc_pkg;
   function automatic int unsigned div_floor(int unsigned n, int unsigned d);
      return n / d;
   endfunction

   function automatic int unsigned div_ceil(int unsigned n, int unsigned d);
      return (n + d - 1) / d;
   endfunction

   function automatic int unsigned min_u(int unsigned a, int unsigned b);
      return (a < b) ? a : b;
   endfunction

   // Shortest accepted period for one mode/limit pair (index = {mode, lim}).
   function automatic int unsigned pmin_for(int unsigned idx, int unsigned ref_hz,
                                            int unsigned f512, int unsigned f256,
                                            int unsigned l1, int unsigned l2,
                                            int unsigned l3);
      int unsigned cap;
      int unsigned f;
      cap = idx[2] ? f256 : f512;
      case (idx[1:0])
         2'd1:    f = min_u(l1, cap);
         2'd2:    f = min_u(l2, cap);
         2'd3:    f = min_u(l3, cap);
         default: f = cap;
      endcase
      return div_ceil(ref_hz, f);
   endfunction
endpackage

// File: rtl/rc_period_counter.sv
module rc_period_counter #(
   parameter int unsigned CW  = 10,
   parameter int unsigned TMO = 657
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   output logic          meas_v,
   output logic          tmo_hit,
   output logic [CW-1:0] meas_cnt
);
   logic [CW-1:0] cnt_q;
   logic          armed_q;

   assign meas_cnt = cnt_q;
   assign meas_v   = stb && armed_q;
   assign tmo_hit  = !stb && (cnt_q == CW'(TMO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (stb) begin
         cnt_q   <= CW'(1);
         armed_q <= 1'b1;
      end else if (tmo_hit) begin
         cnt_q   <= CW'(1);
         armed_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/rc_window_select.sv
module rc_window_select #(
   parameter int unsigned CW       = 10,
   parameter int unsigned REF_HZ   = 12_288_000,
   parameter int unsigned F512_HZ  = 105_000,
   parameter int unsigned F256_HZ  = 195_000,
   parameter int unsigned LIM1_HZ  = 48_000,
   parameter int unsigned LIM2_HZ  = 96_000,
   parameter int unsigned LIM3_HZ  = 192_000,
   parameter bit          LIMIT_EN = 1'b1
) (
   input  logic          mode_256,
   input  logic [1:0]    lim_sel,
   output logic [CW-1:0] pmin
);
   localparam int unsigned NSET = 8;
   logic [CW-1:0] tab [NSET];

   for (genvar i = 0; i < NSET; i++) begin : g_tab
      localparam int unsigned P = rc_pkg::pmin_for(i, REF_HZ, F512_HZ, F256_HZ,
                                                   LIM1_HZ, LIM2_HZ, LIM3_HZ);
      assign tab[i] = CW'(P);
   end

   if (LIMIT_EN) begin : g_lim
      assign pmin = tab[{mode_256, lim_sel}];
   end else begin : g_nolim
      logic unused_lim;
      assign unused_lim = ^lim_sel;
      assign pmin = tab[{mode_256, 2'b00}];
   end
endmodule

// File: rtl/rc_persist_filter.sv
module rc_persist_filter #(
   parameter int unsigned PERSIST = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic bad,
   output logic fault_q,
   output logic sel_q
);
   localparam int unsigned SW = $clog2(PERSIST + 1);
   logic [SW-1:0] streak_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         streak_q <= '0;
         fault_q  <= 1'b1;
         sel_q    <= 1'b1;
      end else if (ev) begin
         if (bad == fault_q) begin
            streak_q <= '0;
         end else if (streak_q == SW'(PERSIST - 1)) begin
            streak_q <= '0;
            fault_q  <= bad;
            sel_q    <= bad;
         end else begin
            streak_q <= streak_q + SW'(1);
         end
      end
   end
endmodule

// File: rtl/rc_rate_checker.sv
module rc_rate_checker #(
   parameter int unsigned REF_HZ   = 12_288_000,
   parameter int unsigned FMIN_HZ  = 28_000,
   parameter int unsigned F512_HZ  = 105_000,
   parameter int unsigned F256_HZ  = 195_000,
   parameter int unsigned LIM1_HZ  = 48_000,
   parameter int unsigned LIM2_HZ  = 96_000,
   parameter int unsigned LIM3_HZ  = 192_000,
   parameter int unsigned TMO_NUM  = 3,
   parameter int unsigned TMO_DEN  = 2,
   parameter int unsigned PERSIST  = 2,
   parameter bit          LIMIT_EN = 1'b1,
   localparam int unsigned PMAX    = rc_pkg::div_floor(REF_HZ, FMIN_HZ),
   localparam int unsigned TMO     = (PMAX * TMO_NUM) / TMO_DEN,
   localparam int unsigned CW      = $clog2(TMO + 1)
) (
   input  logic          clk_xtal,
   input  logic          rst_n,
   input  logic          frame_stb,
   input  logic          mode_256,
   input  logic [1:0]    lim_sel,
   output logic          rate_err,
   output logic          sel_xtal,
   output logic [CW-1:0] period_cnt
);
   if (FMIN_HZ == 0 || FMIN_HZ >= F512_HZ || FMIN_HZ >= F256_HZ) begin : g_bad_rates
      $error("rc_rate_checker: minimum rate must lie below both mode maxima");
   end
   if (TMO_DEN == 0 || TMO <= PMAX) begin : g_bad_tmo
      $error("rc_rate_checker: timeout must exceed the longest good period");
   end
   if (PERSIST == 0) begin : g_bad_persist
      $error("rc_rate_checker: PERSIST must be at least 1");
   end

   logic          meas_v;
   logic          tmo_hit;
   logic [CW-1:0] meas_cnt;
   logic [CW-1:0] pmin;
   logic          in_range;
   logic          ev;
   logic          bad;
   logic [CW-1:0] period_q;

   rc_period_counter #(.CW(CW), .TMO(TMO)) u_cnt (
      .clk      (clk_xtal),
      .rst_n    (rst_n),
      .stb      (frame_stb),
      .meas_v   (meas_v),
      .tmo_hit  (tmo_hit),
      .meas_cnt (meas_cnt)
   );

   rc_window_select #(
      .CW(CW), .REF_HZ(REF_HZ), .F512_HZ(F512_HZ), .F256_HZ(F256_HZ),
      .LIM1_HZ(LIM1_HZ), .LIM2_HZ(LIM2_HZ), .LIM3_HZ(LIM3_HZ),
      .LIMIT_EN(LIMIT_EN)
   ) u_win (
      .mode_256 (mode_256),
      .lim_sel  (lim_sel),
      .pmin     (pmin)
   );

   assign in_range = (meas_cnt >= pmin) && (meas_cnt <= CW'(PMAX));
   assign ev       = meas_v || tmo_hit;
   assign bad      = tmo_hit || !in_range;

   rc_persist_filter #(.PERSIST(PERSIST)) u_flt (
      .clk     (clk_xtal),
      .rst_n   (rst_n),
      .ev      (ev),
      .bad     (bad),
      .fault_q (rate_err),
      .sel_q   (sel_xtal)
   );

   always_ff @(posedge clk_xtal or negedge rst_n) begin
      if (!rst_n)      period_q <= '0;
      else if (meas_v) period_q <= meas_cnt;
   end
   assign period_cnt = period_q;
endmodule

// File: rtl/rc_rate_checker_chk.sv
module rc_rate_checker_chk #(
   parameter int unsigned CW  = 10,
   parameter int unsigned TMO = 657
) (
   input logic          clk_xtal,
   input logic          rst_n,
   input logic          frame_stb,
   input logic          rate_err,
   input logic          sel_xtal,
   input logic [CW-1:0] period_cnt,
   input logic          meas_v,
   input logic          tmo_hit
);
   p_reset_state_r1: assert property (@(posedge clk_xtal)
      !rst_n |=> (rate_err && sel_xtal && period_cnt == '0));

   p_period_on_stb_r2: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      !frame_stb |=> $stable(period_cnt));

   p_hold_quiet_r7: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      !(meas_v || tmo_hit) |=> ($stable(rate_err) && $stable(sel_xtal)));

   p_period_ceiling_r9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      period_cnt <= CW'(TMO));

   p_sel_tracks_r10: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      sel_xtal == rate_err);
endmodule

bind rc_rate_checker rc_rate_checker_chk #(.CW(CW), .TMO(TMO)) u_chk (
   .clk_xtal   (clk_xtal),
   .rst_n      (rst_n),
   .frame_stb  (frame_stb),
   .rate_err   (rate_err),
   .sel_xtal   (sel_xtal),
   .period_cnt (period_cnt),
   .meas_v     (meas_v),
   .tmo_hit    (tmo_hit)
);

// File: tb/tb_rc_rate_checker.sv
module tb_rc_rate_checker;
   localparam int CLK_PERIOD = 10;
   localparam int CW  = 10;
   localparam int TMO = 657;

   logic          clk_xtal = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_stb = 1'b0;
   logic          mode_256 = 1'b0;
   logic [1:0]    lim_sel = 2'd0;
   logic          rate_err;
   logic          sel_xtal;
   logic [CW-1:0] period_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk_xtal = ~clk_xtal;

   rc_rate_checker dut (
      .clk_xtal(clk_xtal), .rst_n(rst_n), .frame_stb(frame_stb),
      .mode_256(mode_256), .lim_sel(lim_sel), .rate_err(rate_err),
      .sel_xtal(sel_xtal), .period_cnt(period_cnt)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One strobe, p cycles after the previous one; returns just after it.
   task automatic frame(int p);
      repeat (p - 1) @(negedge clk_xtal);
      frame_stb = 1'b1;
      @(negedge clk_xtal);
      frame_stb = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rate_err", rate_err, 1);
      chk("R1 sel_xtal", sel_xtal, 1);
      chk("R1 period_cnt", period_cnt, 0);
   endtask

   task automatic t_first_lock();
      frame(50);
      chk("R2 first strobe unmeasured", period_cnt, 0);
      frame(200);
      chk("R2 period", period_cnt, 200);
      chk("R8 one good keeps fault", rate_err, 1);
      frame(200);
      chk("R8 two good clear fault", rate_err, 0);
      chk("R8 pll selected", sel_xtal, 0);
   endtask

   task automatic t_mode512();
      frame(118);
      chk("R3 lower edge good", rate_err, 0);
      frame(117);
      chk("R7 single bad ignored", rate_err, 0);
      chk("R2 period 117", period_cnt, 117);
      frame(118);
      chk("R7 stays clear", sel_xtal, 0);
      frame(438);
      frame(439);
      chk("R7 one long ignored", rate_err, 0);
      frame(439);
      chk("R6 two long set fault", rate_err, 1);
      chk("R6 crystal selected", sel_xtal, 1);
      frame(438);
      frame(438);
      chk("R3 upper edge good", rate_err, 0);
      frame(117);
      frame(117);
      chk("R3 117 bad in mode 0", rate_err, 1);
      frame(200);
      frame(200);
      chk("R8 recover", rate_err, 0);
   endtask

   task automatic t_mode256();
      mode_256 = 1'b1;
      frame(64);
      frame(64);
      chk("R4 64 good", rate_err, 0);
      frame(63);
      frame(63);
      chk("R4 63 bad", rate_err, 1);
      frame(64);
      frame(64);
      chk("R4 recover at 64", rate_err, 0);
   endtask

   task automatic t_limits();
      mode_256 = 1'b1; lim_sel = 2'd1;
      frame(256); frame(256);
      chk("R5 lim1 256 good", rate_err, 0);
      frame(255); frame(255);
      chk("R5 lim1 255 bad", rate_err, 1);
      lim_sel = 2'd2;
      frame(128); frame(128);
      chk("R5 lim2 128 good", rate_err, 0);
      frame(127); frame(127);
      chk("R5 lim2 127 bad", rate_err, 1);
      lim_sel = 2'd3;
      frame(64); frame(64);
      chk("R5 lim3 mode1 64 good", rate_err, 0);
      mode_256 = 1'b0;
      frame(117); frame(117);
      chk("R5 lim3 clipped 117 bad", rate_err, 1);
      frame(118); frame(118);
      chk("R5 lim3 clipped 118 good", rate_err, 0);
      lim_sel = 2'd0;
   endtask

   task automatic t_timeout();
      frame(300);
      frame(300);
      chk("R2 period 300", period_cnt, 300);
      repeat (700) @(negedge clk_xtal);
      chk("R9 one timeout ignored", rate_err, 0);
      repeat (620) @(negedge clk_xtal);
      chk("R9 two timeouts set fault", rate_err, 1);
      chk("R9 period held", period_cnt, 300);
      frame(100);
      chk("R2 strobe after timeout unmeasured", period_cnt, 300);
      frame(200);
      chk("R2 measured after rearm", period_cnt, 200);
      chk("R8 one good after timeout", rate_err, 1);
      frame(200);
      chk("R8 cleared after timeout", rate_err, 0);
      chk("R10 sel matches", sel_xtal, rate_err);
   endtask

   initial begin
      repeat (3) @(negedge clk_xtal);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk_xtal);
      t_first_lock();
      t_mode512();
      t_mode256();
      t_limits();
      t_timeout();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule